// File: doc/BRIEF.md
# I2C Slave Controller with Refusal on Full Buffer

This block is the target side of a standard-mode I2C link. It samples the SCL and SDA pads on a fast system clock and detects START and STOP conditions. It compares the first byte of each transfer against a programmable 7-bit or 10-bit address. It shifts received bytes into an internal byte register and copies each accepted byte into a receive buffer that a host reads through a small register port. In a read transfer it sends a host-supplied transmit byte, most significant bit first. It drives SDA only by pulling it low.

The acknowledge on the ninth clock is automatic, but it depends on two flags. If the receive buffer is still full, or a sticky overflow flag is still pending, the byte is refused. SDA stays released, the buffer keeps its old contents, and the interrupt flag is raised anyway so the host learns of the loss. Some modes also raise the interrupt flag on START and STOP, so that firmware can act as a bus master. The general call address is never answered.

Top module: `i2cTarget`

## Requirements
- R1: After reset every host register reads 0 and SDA is released. Register offsets: 0 control (bits 3:0 mode, bit 4 enable, bit 5 overflow), 1 status (bit 0 buffer full, bit 1 read/write bit of the last matched address, bit 2 START seen, bit 3 STOP seen, bit 4 interrupt flag, cleared by writing 1 to bit 4), 2 data (a read returns the received byte, a write sets the transmit byte), 3 address bits 7:0, 4 address bits 9:8 in bits 1:0.
- R2: Mode code 1 selects a 7-bit slave, 2 a 10-bit slave, and 5 and 6 the same slaves with START/STOP interrupts. Code 4 gives START/STOP interrupts with the slave idle, and every other code leaves the block idle without interrupts. A START sets status bit 2 and clears bit 3, and a STOP does the reverse. Either one raises the interrupt flag only under codes 4, 5 and 6.
- R3: In 7-bit mode, a first byte whose bits 7:1 equal address bits 6:0 is acknowledged, with SDA held low through the ninth SCL pulse. It is copied into the data buffer, buffer full and the interrupt flag are set, and its bit 0 is recorded as the read/write bit. Any other address gets no acknowledge and no interrupt.
- R4: The general call address 0 is never acknowledged, even when the programmed address is 0.
- R5: Data bytes after a write match are shifted in MSB first on SCL rising edges, acknowledged and loaded into the data buffer.
- R6: If buffer full or overflow is set when a byte ends, SDA stays released in the ninth clock and the data buffer keeps its previous value, but the interrupt flag is still set.
- R7: A byte that ends while buffer full is set sets the overflow flag. Overflow stays set, and bytes keep being refused, until the host writes control bit 5 as 0.
- R8: Reading the data register clears buffer full.
- R9: In 10-bit mode the header 11110, a9, a8, 0 is acknowledged, then a second byte equal to address bits 7:0 is acknowledged. After that, a repeated START with the header's R/W bit set enters transmit. A wrong header, a wrong second byte, or a read header with no full match since the last STOP gets no acknowledge.
- R10: In transmit, the transmit byte is loaded when the address acknowledge clock ends and again after each byte the master acknowledges. Bits are driven MSB first and SDA changes only while SCL is low. A master NACK releases SDA for the rest of the transfer.
- R11: With enable at 0, SDA is never driven, the START/STOP status bits stay clear and no byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL pad input |
| sdaIn | input | 1 | SDA pad input |
| sdaDriveLow | output | 1 | 1 pulls the SDA pad low, 0 releases it |
| regWrEn | input | 1 | Host register write strobe |
| regRdEn | input | 1 | Host register read strobe |
| regAddr | input | 3 | Host register offset |
| regWrData | input | 8 | Host write data |
| regRdData | output | 8 | Host read data, combinational from regAddr |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest case to reach is a byte that is refused while overflow is still pending and buffer full has already been cleared. The refusal must then come from the sticky flag alone. The bench gets there by leaving the buffer unread across one data byte, reading it, and sending a further byte before it clears overflow. It also sweeps every 7-bit address and reaches the 10-bit read through a repeated START that follows a full two-byte match.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd1;
  localparam logic [REG_AW-1:0] RA_DATA = 3'd2;
  localparam logic [REG_AW-1:0] RA_ADLO = 3'd3;
  localparam logic [REG_AW-1:0] RA_ADHI = 3'd4;

  localparam int CTRL_EN_BIT  = 4;
  localparam int CTRL_OVF_BIT = 5;
  localparam int STAT_IRQ_BIT = 4;

  localparam logic [4:0] HDR10_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_EVAL, ST_ACKWAIT, ST_ACKHOLD, ST_TX, ST_TXACK, ST_SKIP
  } tgtState_t;

  typedef enum logic [1:0] {PH_ADDR1, PH_ADDR2, PH_DATA} tgtPhase_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic cntUp;
    logic clrCnt;
    logic loadTx;
    logic loadBuf;
    logic setOvf;
    logic setIrq;
    logic setRw;
    logic clrRw;
  } tgtStrobe_t;
endpackage

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  tgtStrobe_t        strobe,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              sclS,
  output logic              sdaS,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              bufFull,
  output logic              ovfFlag,
  output logic [3:0]        modeSel,
  output logic              enable,
  output logic              addrHit7,
  output logic              hdrHit,
  output logic              lowHit,
  output logic              rwBit,
  output logic              txBit,
  output logic              irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic [BYTE_W-1:0] shiftReg, rxBuf, txBuf, addrLo;
  logic [1:0] addrHi;
  logic rwReg, startSeen, stopSeen, irqReg;
  logic wrCtrl, wrStat, wrData, rdData;

  // pad synchronisers, depth picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[LAST];
  assign sdaS = sdaPipe[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign wrCtrl = regWrEn && (regAddr == RA_CTRL);
  assign wrStat = regWrEn && (regAddr == RA_STAT);
  assign wrData = regWrEn && (regAddr == RA_DATA);
  assign rdData = regRdEn && (regAddr == RA_DATA);

  // shift register and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (strobe.loadTx)        shiftReg <= txBuf;
      else if (strobe.shiftIn)  shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
      else if (strobe.shiftOut) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};
      if (strobe.clrCnt)                         bitCnt <= '0;
      else if (strobe.shiftIn || strobe.cntUp)   bitCnt <= bitCnt + 1'b1;
    end
  end

  // host-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel <= '0;
      enable  <= 1'b0;
      ovfFlag <= 1'b0;
      bufFull <= 1'b0;
      rxBuf   <= '0;
      txBuf   <= '0;
      addrLo  <= '0;
      addrHi  <= '0;
      rwReg   <= 1'b0;
      irqReg  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        modeSel <= regWrData[3:0];
        enable  <= regWrData[CTRL_EN_BIT];
      end
      if (strobe.setOvf)  ovfFlag <= 1'b1;
      else if (wrCtrl)    ovfFlag <= regWrData[CTRL_OVF_BIT];
      if (strobe.loadBuf) begin
        bufFull <= 1'b1;
        rxBuf   <= shiftReg;
      end else if (rdData) begin
        bufFull <= 1'b0;
      end
      if (wrData) txBuf <= regWrData;
      if (regWrEn && regAddr == RA_ADLO) addrLo <= regWrData;
      if (regWrEn && regAddr == RA_ADHI) addrHi <= regWrData[1:0];
      if (strobe.setRw)      rwReg <= 1'b1;
      else if (strobe.clrRw) rwReg <= 1'b0;
      if (strobe.setIrq)                          irqReg <= 1'b1;
      else if (wrStat && regWrData[STAT_IRQ_BIT]) irqReg <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else if (startEv && enable) begin
      startSeen <= 1'b1;
      stopSeen  <= 1'b0;
    end else if (stopEv && enable) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b1;
    end else if (!enable) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      RA_CTRL: regRdData = {2'b00, ovfFlag, enable, modeSel};
      RA_STAT: regRdData = {3'b000, irqReg, stopSeen, startSeen, rwReg, bufFull};
      RA_DATA: regRdData = rxBuf;
      RA_ADLO: regRdData = addrLo;
      RA_ADHI: regRdData = {6'b0, addrHi};
      default: regRdData = '0;
    endcase
  end

  assign addrHit7 = (shiftReg[7:1] == addrLo[6:0]) && (shiftReg[7:1] != 7'd0);
  assign hdrHit   = (shiftReg[7:1] == {HDR10_PREFIX, addrHi});
  assign lowHit   = (shiftReg == addrLo);
  assign rwBit    = shiftReg[0];
  assign txBit    = shiftReg[BYTE_W-1];
  assign irq      = irqReg;

  a_r6_load_only_when_free: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBuf |-> (!bufFull && !ovfFlag));
  a_r8_full_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(strobe.loadBuf));
  a_r7_ovf_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(strobe.setOvf) || $past(wrCtrl && regWrData[CTRL_OVF_BIT])));
  a_r2_start_bits: assert property (@(posedge clk) disable iff (!rstN)
    (startEv && enable) |=> (startSeen && !stopSeen));
endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [3:0]       modeSel,
  input  logic             sclS,
  input  logic             sdaS,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             bufFull,
  input  logic             ovfFlag,
  input  logic             addrHit7,
  input  logic             hdrHit,
  input  logic             lowHit,
  input  logic             rwBit,
  input  logic             txBit,
  output tgtStrobe_t       strobe,
  output logic             sdaDriveLow
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  tgtState_t state, nState, afterAck, nAfter;
  tgtPhase_t phase, nPhase;
  logic ackFlag, nAck, tenArmed, nArmed, masterAck, nMAck;
  logic slave7, slave10, slaveOn, ssIrqOn;
  logic hit, goTx, ackOk;

  assign slave7  = !modeSel[3] && (modeSel[1:0] == 2'b01);
  assign slave10 = !modeSel[3] && (modeSel[1:0] == 2'b10);
  assign slaveOn = slave7 || slave10;
  assign ssIrqOn = !modeSel[3] && modeSel[2] && (modeSel[1:0] != 2'b11);

  always_comb begin
    strobe = '0;
    nState = state;
    nPhase = phase;
    nAck   = ackFlag;
    nAfter = afterAck;
    nArmed = tenArmed;
    nMAck  = masterAck;
    hit    = 1'b0;
    goTx   = 1'b0;
    ackOk  = 1'b0;
    if (!enable) begin
      nState = ST_IDLE;
      nArmed = 1'b0;
    end else if (startEv) begin
      strobe.setIrq = ssIrqOn;
      strobe.clrCnt = 1'b1;
      nPhase = PH_ADDR1;
      nState = slaveOn ? ST_RX : ST_SKIP;
    end else if (stopEv) begin
      strobe.setIrq = ssIrqOn;
      nState = ST_IDLE;
      nArmed = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            strobe.shiftIn = 1'b1;
            if (bitCnt == LAST_BIT) nState = ST_EVAL;
          end
        end
        ST_EVAL: begin
          case (phase)
            PH_ADDR1: begin
              if (slave7) begin
                hit  = addrHit7;
                goTx = rwBit;
                nPhase = PH_DATA;
              end else if (hdrHit && !rwBit) begin
                hit = 1'b1;
                nPhase = PH_ADDR2;
              end else if (hdrHit && rwBit && tenArmed) begin
                hit  = 1'b1;
                goTx = 1'b1;
              end
            end
            PH_ADDR2: begin
              hit = lowHit;
              nPhase = PH_DATA;
            end
            default: hit = 1'b1;
          endcase
          ackOk = hit && !bufFull && !ovfFlag;
          if (hit) begin
            strobe.setIrq = 1'b1;
            if (ackOk) strobe.loadBuf = 1'b1;
            else if (bufFull) strobe.setOvf = 1'b1;
          end
          if (hit && phase == PH_ADDR1) begin
            strobe.setRw = rwBit;
            strobe.clrRw = !rwBit;
          end
          if (ackOk && phase == PH_ADDR2) nArmed = 1'b1;
          nAck = ackOk;
          if (!ackOk) nAfter = (hit && phase == PH_DATA) ? ST_RX : ST_SKIP;
          else        nAfter = goTx ? ST_TX : ST_RX;
          nState = ST_ACKWAIT;
        end
        ST_ACKWAIT: if (sclFall) nState = ST_ACKHOLD;
        ST_ACKHOLD: begin
          if (sclFall) begin
            strobe.clrCnt = 1'b1;
            strobe.loadTx = (afterAck == ST_TX);
            nState = afterAck;
          end
        end
        ST_TX: begin
          if (sclRise) strobe.cntUp = 1'b1;
          else if (sclFall) begin
            if (bitCnt == FULL_CNT) nState = ST_TXACK;
            else strobe.shiftOut = 1'b1;
          end
        end
        ST_TXACK: begin
          if (sclRise) nMAck = !sdaS;
          else if (sclFall) begin
            if (masterAck) begin
              strobe.loadTx = 1'b1;
              strobe.clrCnt = 1'b1;
              strobe.setIrq = 1'b1;
              nState = ST_TX;
            end else begin
              nState = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR1;
      ackFlag   <= 1'b0;
      afterAck  <= ST_SKIP;
      tenArmed  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= nState;
      phase     <= nPhase;
      ackFlag   <= nAck;
      afterAck  <= nAfter;
      tenArmed  <= nArmed;
      masterAck <= nMAck;
    end
  end

  assign sdaDriveLow = enable &&
    (((state == ST_ACKHOLD) && ackFlag) || ((state == ST_TX) && !txBit));

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$stable(sdaDriveLow)) |-> !sclS);
  a_r3_ack_after_eight: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKHOLD && ackFlag) |-> (bitCnt == FULL_CNT));
  a_r10_tx_count: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX) |-> (bitCnt <= FULL_CNT));
endmodule

// File: rtl/i2cTarget.sv
module i2cTarget
  import i2cTgtPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irq
);
  tgtStrobe_t strobe;
  logic sclS, sdaS, sclRise, sclFall, startEv, stopEv;
  logic [CNT_W-1:0] bitCnt;
  logic bufFull, ovfFlag, enable, addrHit7, hdrHit, lowHit, rwBit, txBit;
  logic [3:0] modeSel;

  i2cTgtDatapath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .bitCnt(bitCnt),
    .bufFull(bufFull), .ovfFlag(ovfFlag), .modeSel(modeSel), .enable(enable),
    .addrHit7(addrHit7), .hdrHit(hdrHit), .lowHit(lowHit), .rwBit(rwBit),
    .txBit(txBit), .irq(irq)
  );

  i2cTgtControl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .bitCnt(bitCnt),
    .bufFull(bufFull), .ovfFlag(ovfFlag), .addrHit7(addrHit7),
    .hdrHit(hdrHit), .lowHit(lowHit), .rwBit(rwBit), .txBit(txBit),
    .strobe(strobe), .sdaDriveLow(sdaDriveLow)
  );
endmodule

// File: tb/tb_i2cTarget.sv
module tb_i2cTarget;
  localparam int Q = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sdaDriveLow, irq;
  wire  sdaBus = mSda & ~sdaDriveLow;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit ack;
  logic [7:0] d, s;

  always #2 clk = ~clk;

  i2cTarget dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic i2cStart();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(2*Q);
    mSda = 1'b0; tick(2*Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic i2cStop();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(2*Q);
    mSda = 1'b1; tick(2*Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q);
      mScl = 1'b1; tick(2*Q);
      mScl = 1'b0; tick(Q);
    end
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    acked = (sdaBus == 1'b0);
    tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] v);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      mScl = 1'b1; tick(Q);
      v[i] = sdaBus;
      tick(Q);
      mScl = 1'b0;
    end
    tick(Q);
    mSda = giveAck ? 1'b0 : 1'b1; tick(Q);
    mScl = 1'b1; tick(2*Q);
    mScl = 1'b0; tick(Q);
    mSda = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1 reset state
    regRead(3'd0, d); checkEq("R1 control after reset", d, 0);
    regRead(3'd1, d); checkEq("R1 status after reset", d, 0);
    checkEq("R1 SDA released after reset", sdaDriveLow, 0);

    // R3 sweep every 7-bit address against own address 0x5A
    regWrite(3'd3, 8'h5A);
    regWrite(3'd0, 8'h11);
    for (int a = 0; a < 128; a++) begin
      bit hit;
      hit = (a == 8'h5A);
      i2cStart();
      writeByte({a[6:0], 1'b0}, ack);
      i2cStop();
      checkEq("R3 address ack", ack, hit);
      regRead(3'd1, s);
      checkEq("R3 irq on match only", s[4], hit);
      if (hit) begin
        checkEq("R3 buffer full on match", s[0], 1);
        regRead(3'd2, d);
        checkEq("R3 address byte loaded", d, 8'hB4);
        regRead(3'd1, s);
        checkEq("R8 read clears buffer full", s[0], 0);
        regWrite(3'd1, 8'h10);
      end
    end
    regRead(3'd1, s);
    checkEq("R2 STOP sets P clears S", s[3:2], 2'b10);

    // R4 general call never answered
    regWrite(3'd3, 8'h00);
    i2cStart(); writeByte(8'h00, ack); i2cStop();
    checkEq("R4 general call not acked", ack, 0);
    regRead(3'd1, s); checkEq("R4 no irq on general call", s[4], 0);
    regWrite(3'd3, 8'h5A);

    // R5 data sweep
    i2cStart(); writeByte(8'hB4, ack);
    checkEq("R3 write address acked", ack, 1);
    regRead(3'd1, s); checkEq("R3 rw bit write", s[1], 0);
    checkEq("R2 START sets S clears P", s[3:2], 2'b01);
    regRead(3'd2, d);
    for (int v = 0; v < 256; v += 5) begin
      writeByte(v[7:0], ack);
      checkEq("R5 data ack", ack, 1);
      regRead(3'd2, d);
      checkEq("R5 data loaded", d, v);
    end
    i2cStop();
    regWrite(3'd1, 8'h10);
    regRead(3'd1, s); checkEq("R2 no irq from STOP in code 1", s[4], 0);

    // R2 START/STOP interrupts in code 5
    regWrite(3'd0, 8'h15);
    i2cStart();
    regRead(3'd1, s); checkEq("R2 START irq in code 5", s[4], 1);
    regWrite(3'd1, 8'h10);
    i2cStop();
    regRead(3'd1, s); checkEq("R2 STOP irq in code 5", s[4], 1);
    regWrite(3'd1, 8'h10);
    regWrite(3'd0, 8'h11);

    // R6 / R7 refusal on full buffer and sticky overflow
    i2cStart(); writeByte(8'hB4, ack);
    checkEq("R3 address acked before overflow", ack, 1);
    regWrite(3'd1, 8'h10);
    writeByte(8'h11, ack);
    checkEq("R6 byte refused on full buffer", ack, 0);
    regRead(3'd1, s); checkEq("R6 irq still raised", s[4], 1);
    regRead(3'd0, d); checkEq("R7 overflow set", d[5], 1);
    regRead(3'd2, d); checkEq("R6 buffer unchanged", d, 8'hB4);
    writeByte(8'h22, ack);
    checkEq("R7 overflow alone refuses", ack, 0);
    regRead(3'd2, d); checkEq("R7 buffer unchanged under overflow", d, 8'hB4);
    regRead(3'd0, d); checkEq("R7 overflow sticky", d[5], 1);
    regWrite(3'd0, 8'h11);
    writeByte(8'h33, ack);
    checkEq("R7 accept after clear", ack, 1);
    regRead(3'd2, d); checkEq("R7 byte loaded after clear", d, 8'h33);
    i2cStop();
    regWrite(3'd1, 8'h10);

    // R10 slave transmit, 7-bit
    regWrite(3'd2, 8'h96);
    i2cStart(); writeByte(8'hB5, ack);
    checkEq("R10 read address acked", ack, 1);
    regRead(3'd1, s); checkEq("R3 rw bit read", s[1], 1);
    regRead(3'd2, d);
    regWrite(3'd2, 8'h3C);
    readByte(1'b1, d); checkEq("R10 first byte sent", d, 8'h96);
    regWrite(3'd2, 8'h71);
    readByte(1'b0, d); checkEq("R10 reload after master ack", d, 8'h3C);
    tick(Q);
    checkEq("R10 released after NACK", sdaDriveLow, 0);
    i2cStop();

    // R9 10-bit addressing, own address 0x2C7
    regWrite(3'd4, 8'h02);
    regWrite(3'd3, 8'hC7);
    regWrite(3'd0, 8'h12);
    i2cStart(); writeByte(8'hF5, ack);
    checkEq("R9 read header without match refused", ack, 0);
    i2cStop();
    i2cStart(); writeByte(8'hF6, ack);
    checkEq("R9 wrong header refused", ack, 0);
    i2cStop();
    i2cStart(); writeByte(8'hF4, ack);
    checkEq("R9 header acked", ack, 1);
    regRead(3'd2, d); checkEq("R9 header loaded", d, 8'hF4);
    writeByte(8'hC8, ack);
    checkEq("R9 wrong low byte refused", ack, 0);
    i2cStop();
    i2cStart(); writeByte(8'hF4, ack);
    regRead(3'd2, d);
    writeByte(8'hC7, ack);
    checkEq("R9 low byte acked", ack, 1);
    regRead(3'd2, d); checkEq("R9 low byte loaded", d, 8'hC7);
    writeByte(8'h3E, ack);
    checkEq("R9 data after match acked", ack, 1);
    regRead(3'd2, d); checkEq("R9 data loaded", d, 8'h3E);
    regWrite(3'd2, 8'h5D);
    i2cStart(); writeByte(8'hF5, ack);
    checkEq("R9 read header after match acked", ack, 1);
    regRead(3'd2, d);
    readByte(1'b0, d); checkEq("R9 10-bit transmit byte", d, 8'h5D);
    i2cStop();

    // R2 code 4: interrupts only, slave idle
    regWrite(3'd0, 8'h14);
    regWrite(3'd1, 8'h10);
    i2cStart();
    regRead(3'd1, s); checkEq("R2 code 4 START irq", s[4], 1);
    writeByte(8'hB4, ack);
    checkEq("R2 code 4 slave idle", ack, 0);
    i2cStop();

    // R11 disabled
    regWrite(3'd0, 8'h01);
    regRead(3'd1, s); checkEq("R11 status bits clear when off", s[3:2], 0);
    i2cStart(); writeByte(8'hB4, ack);
    checkEq("R11 no ack when off", ack, 0);
    regRead(3'd1, s); checkEq("R11 START ignored when off", s[2], 0);
    i2cStop();
    checkEq("R11 SDA released when off", sdaDriveLow, 0);

    finishRun();
  end
endmodule